// File: doc/BRIEF.md
# Configuration Image Preamble Locator

The block sits on a byte stream that carries a configuration image and strips the descriptive lead-in in front of the real configuration data. It consumes the image one byte per accepted handshake and never stores it. Its first step throws away a fixed block of opening bytes. It then steps over a fixed number of length-prefixed text fields, counting the bytes of each field instead of reading them. After the last field it looks for a synchronisation run of four consecutive 0xFF bytes.

When the run is complete, the block reports the byte index at which the run began and pulses a marker. It then sends the payload downstream, starting with the first byte of the run. The four preamble bytes have already been consumed by the time the run is recognised, so they are replayed from a constant on the output. After that, bytes flow straight from input to output. If the image ends before a run is found, the block raises a one-cycle error and goes back to waiting for a fresh image.

Top module: `cfg_image_scanner`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0, sync_found is 0, sync_missing is 0 and payload_offset is 0.
- R2: The first 15 accepted bytes of an image are consumed and never forwarded, whatever their values, including 0xFF.
- R3: Four fields follow the opening bytes. The first byte of each field holds an unsigned length L, and the next field begins L+3 bytes after that length byte. All field bytes are consumed without being forwarded, and 0xFF bytes inside them never count toward the preamble.
- R4: After the fourth field the block examines the bytes one at a time for four consecutive 0xFF bytes. Any byte other than 0xFF sets the run count back to zero.
- R5: sync_found is high for exactly one cycle, in the cycle after the clock edge that accepts the fourth 0xFF of the run. In that same cycle payload_offset takes the 0-based index of the first 0xFF of the run, where the first byte of the image is index 0. payload_offset keeps that value until the next sync_found.
- R6: The payload is forwarded in order, starting with the first 0xFF of the run. Four 0xFF bytes are replayed, with out_valid high and in_ready low, beginning in the cycle that sync_found is high. After the replay, the input bytes follow.
- R7: Once the replay is complete, in_ready equals out_ready, out_valid equals in_valid, and out_data equals in_data in the same cycle, with no register on the path.
- R8: out_last marks the final byte of the image on the output. If the image ends on the fourth preamble byte, out_last is set on the fourth replayed byte.
- R9: If the byte flagged as last is accepted before a run is found, sync_missing is high for one cycle after that edge. Nothing is forwarded, and the next accepted byte is treated as index 0 of a new image.
- R10: After a normal image ends, the next accepted byte starts a new image, and header skipping and offset counting start again from index 0.
- R11: During the replay, while out_ready is low, out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input image byte |
| in_last | input | 1 | Input byte is the final one of the image |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Payload byte present |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Payload byte is the final one of the image |
| out_ready | input | 1 | Downstream accepts the payload byte |
| sync_found | output | 1 | One-cycle pulse when the preamble run completes |
| payload_offset | output | 16 | Byte index of the first payload byte in the image |
| sync_missing | output | 1 | One-cycle pulse when an image ends without a preamble |

## Verification
sync_found, payload_offset and sync_missing are due in the cycle after the edge that accepts the deciding byte. The first replayed 0xFF appears in that same cycle, and pass-through bytes appear in the cycle they are offered. The bench evaluates each accept at the falling edge that comes before the deciding rising edge. It then compares the registered results at the next falling edge, so every expected value is tied to a known edge. Output bytes are popped from an expected queue only on falling edges where out_valid and out_ready are both high. The relation between in_ready and out_ready is checked on every cycle of the replay and pass phases.

// File: rtl/cis_pkg.sv
package cis_pkg;

    typedef enum logic [1:0] {
        PH_HDR  = 2'd0,
        PH_HUNT = 2'd1,
        PH_EMIT = 2'd2,
        PH_PASS = 2'd3
    } scan_phase_e;

    typedef enum logic [1:0] {
        W_SKIP = 2'd0,
        W_LEN  = 2'd1,
        W_BODY = 2'd2,
        W_DONE = 2'd3
    } walk_phase_e;

endpackage

// File: rtl/cis_hdr_walker.sv
module cis_hdr_walker
    import cis_pkg::*;
#(
    parameter int SKIP_BYTES  = 15,
    parameter int N_FIELDS    = 4,
    parameter int FIELD_EXTRA = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] data,
    output logic       hdr_end
);
    localparam int SKIP_W = $clog2(SKIP_BYTES + 1);
    localparam int FIDX_W = (N_FIELDS > 1) ? $clog2(N_FIELDS) : 1;
    localparam int REM_W  = $clog2(255 + FIELD_EXTRA + 1);

    typedef struct packed {
        walk_phase_e       ph;
        logic [SKIP_W-1:0] skip;
        logic [FIDX_W-1:0] fidx;
        logic [REM_W-1:0]  rem;
    } walk_s;

    walk_s w_d, w_q;
    logic  field_end;
    logic [REM_W-1:0] len_ext;

    always_comb begin
        w_d       = w_q;
        field_end = 1'b0;
        hdr_end   = 1'b0;
        len_ext   = REM_W'(data) + REM_W'(FIELD_EXTRA);
        if (clr) begin
            w_d.ph   = W_SKIP;
            w_d.skip = '0;
            w_d.fidx = '0;
            w_d.rem  = '0;
        end else if (step) begin
            case (w_q.ph)
                W_SKIP: begin
                    if (w_q.skip == SKIP_W'(SKIP_BYTES - 1)) begin
                        w_d.ph = W_LEN;
                    end else begin
                        w_d.skip = w_q.skip + 1'b1;
                    end
                end
                W_LEN: begin
                    if (len_ext == '0) begin
                        field_end = 1'b1;
                    end else begin
                        w_d.rem = len_ext;
                        w_d.ph  = W_BODY;
                    end
                end
                W_BODY: begin
                    if (w_q.rem == REM_W'(1)) begin
                        field_end = 1'b1;
                    end else begin
                        w_d.rem = w_q.rem - 1'b1;
                    end
                end
                default: ;
            endcase
            if (field_end) begin
                if (w_q.fidx == FIDX_W'(N_FIELDS - 1)) begin
                    w_d.ph  = W_DONE;
                    hdr_end = 1'b1;
                end else begin
                    w_d.fidx = w_q.fidx + 1'b1;
                    w_d.ph   = W_LEN;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

endmodule

// File: rtl/cis_sync_hunter.sv
module cis_sync_hunter #(
    parameter int         SYNC_LEN  = 4,
    parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] data,
    output logic       hit
);
    localparam int RUN_W = $clog2(SYNC_LEN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } hunt_s;

    hunt_s h_d, h_q;
    logic  is_sync;

    always_comb begin
        h_d     = h_q;
        is_sync = (data == SYNC_BYTE);
        hit     = 1'b0;
        if (clr) begin
            h_d.run = '0;
        end else if (step) begin
            if (!is_sync) begin
                h_d.run = '0;
            end else if (h_q.run == RUN_W'(SYNC_LEN - 1)) begin
                h_d.run = '0;
                hit     = 1'b1;
            end else begin
                h_d.run = h_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

endmodule

// File: rtl/cis_payload_port.sv
module cis_payload_port #(
    parameter int         SYNC_LEN  = 4,
    parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       start_last,
    input  logic       pass_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       out_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic       pass_ready,
    output logic       replay_done
);
    localparam int CNT_W = (SYNC_LEN > 1) ? $clog2(SYNC_LEN) : 1;

    typedef struct packed {
        logic             act;
        logic             last;
        logic [CNT_W-1:0] cnt;
    } port_s;

    port_s p_d, p_q;
    logic  at_end;

    always_comb begin
        p_d         = p_q;
        at_end      = (p_q.cnt == CNT_W'(SYNC_LEN - 1));
        replay_done = p_q.act & out_ready & at_end;
        if (start) begin
            p_d.act  = 1'b1;
            p_d.last = start_last;
            p_d.cnt  = '0;
        end else if (p_q.act && out_ready) begin
            if (at_end) begin
                p_d.act  = 1'b0;
                p_d.last = 1'b0;
                p_d.cnt  = '0;
            end else begin
                p_d.cnt = p_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign out_valid  = p_q.act | (pass_en & in_valid);
    assign out_data   = p_q.act ? SYNC_BYTE : in_data;
    assign out_last   = p_q.act ? (p_q.last & at_end) : (pass_en & in_last);
    assign pass_ready = pass_en & out_ready;

endmodule

// File: rtl/cfg_image_scanner.sv
module cfg_image_scanner
    import cis_pkg::*;
#(
    parameter int         OFF_W       = 16,
    parameter int         SKIP_BYTES  = 15,
    parameter int         N_FIELDS    = 4,
    parameter int         FIELD_EXTRA = 2,
    parameter int         SYNC_LEN    = 4,
    parameter logic [7:0] SYNC_BYTE   = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready,
    output logic             sync_found,
    output logic [OFF_W-1:0] payload_offset,
    output logic             sync_missing
);
    typedef struct packed {
        scan_phase_e      ph;
        logic [OFF_W-1:0] pos;
        logic [OFF_W-1:0] off;
        logic             found;
        logic             miss;
    } scan_s;

    scan_s       s_d, s_q;
    scan_phase_e cur_ph;
    logic        acc, img_end;
    logic        walk_step, walk_clr, hdr_end;
    logic        hunt_step, hunt_clr, hit;
    logic        pass_en, pass_ready, replay_done;

    assign cur_ph    = s_q.ph;
    assign pass_en   = (s_q.ph == PH_PASS);
    assign in_ready  = (s_q.ph == PH_HDR) | (s_q.ph == PH_HUNT) | pass_ready;
    assign acc       = in_valid & in_ready;
    assign img_end   = acc & in_last;
    assign walk_step = acc & (s_q.ph == PH_HDR);
    assign walk_clr  = (s_q.ph != PH_HDR) | img_end;
    assign hunt_step = acc & (s_q.ph == PH_HUNT);
    assign hunt_clr  = (s_q.ph != PH_HUNT);

    cis_hdr_walker #(
        .SKIP_BYTES (SKIP_BYTES),
        .N_FIELDS   (N_FIELDS),
        .FIELD_EXTRA(FIELD_EXTRA)
    ) u_walker (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (walk_clr),
        .step   (walk_step),
        .data   (in_data),
        .hdr_end(hdr_end)
    );

    cis_sync_hunter #(
        .SYNC_LEN (SYNC_LEN),
        .SYNC_BYTE(SYNC_BYTE)
    ) u_hunter (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (hunt_clr),
        .step (hunt_step),
        .data (in_data),
        .hit  (hit)
    );

    cis_payload_port #(
        .SYNC_LEN (SYNC_LEN),
        .SYNC_BYTE(SYNC_BYTE)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (hit),
        .start_last (in_last),
        .pass_en    (pass_en),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .pass_ready (pass_ready),
        .replay_done(replay_done)
    );

    always_comb begin
        s_d       = s_q;
        s_d.found = 1'b0;
        s_d.miss  = 1'b0;
        if (acc) begin
            s_d.pos = s_q.pos + 1'b1;
        end
        if (img_end) begin
            s_d.pos = '0;
        end
        case (s_q.ph)
            PH_HDR: begin
                if (img_end) begin
                    s_d.miss = 1'b1;
                end else if (hdr_end) begin
                    s_d.ph = PH_HUNT;
                end
            end
            PH_HUNT: begin
                if (hit) begin
                    s_d.found = 1'b1;
                    s_d.off   = s_q.pos - OFF_W'(SYNC_LEN - 1);
                    s_d.ph    = PH_EMIT;
                end else if (img_end) begin
                    s_d.miss = 1'b1;
                    s_d.ph   = PH_HDR;
                end
            end
            PH_EMIT: begin
                if (replay_done) begin
                    s_d.ph = out_last ? PH_HDR : PH_PASS;
                end
            end
            PH_PASS: begin
                if (img_end) begin
                    s_d.ph = PH_HDR;
                end
            end
            default: s_d.ph = PH_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_found     = s_q.found;
    assign sync_missing   = s_q.miss;
    assign payload_offset = s_q.off;

endmodule

module cfg_image_scanner_chk
    import cis_pkg::*;
#(
    parameter int         OFF_W     = 16,
    parameter logic [7:0] SYNC_BYTE = 8'hFF
) (
    input logic             clk,
    input logic             rst_n,
    input scan_phase_e      cur_ph,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             out_ready,
    input logic             sync_found,
    input logic [OFF_W-1:0] payload_offset,
    input logic             sync_missing
);
    // R5
    found_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_found |=> !sync_found);

    // R5
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(payload_offset) |-> sync_found);

    // R9
    miss_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_missing |-> (cur_ph == PH_HDR) && !out_valid && !sync_found);

    // R6
    replay_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_EMIT) |-> !in_ready && out_valid && (out_data == SYNC_BYTE));

    // R7
    pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ph == PH_PASS) |-> (in_ready == out_ready) && (out_valid == in_valid));

    // R11
    replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_ph == PH_EMIT) && !out_ready) |=> $stable(out_data) && $stable(out_last));

    // R2
    no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_ph == PH_HDR) || (cur_ph == PH_HUNT)) |-> !out_valid);

endmodule

bind cfg_image_scanner cfg_image_scanner_chk #(
    .OFF_W    (OFF_W),
    .SYNC_BYTE(SYNC_BYTE)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_ph        (cur_ph),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_last      (out_last),
    .out_ready     (out_ready),
    .sync_found    (sync_found),
    .payload_offset(payload_offset),
    .sync_missing  (sync_missing)
);

// File: tb/cfg_image_scanner_test.sv
module cfg_image_scanner_test;
    typedef logic [7:0] u8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        sync_found;
    logic [15:0] payload_offset;
    logic        sync_missing;

    always #5 clk = ~clk;

    cfg_image_scanner uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .sync_found(sync_found), .payload_offset(payload_offset), .sync_missing(sync_missing)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit summary_done = 0;
    bit rdy_mode = 0;

    u8  exp_data[$];
    bit exp_last[$];
    int exp_start = -1;
    int acc_idx = 0;
    bit pend_found = 0;
    bit pend_miss = 0;
    int pend_off = 0;
    bit in_pass = 0;
    int replay_left = 0;
    bit prev_stall = 0;
    u8  prev_data = 0;
    bit prev_last = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    // Expected payload start from the header rules, -1 if none
    function automatic int find_start(input u8 img[$]);
        int idx = 15;
        for (int f = 0; f < 4; f++) begin
            if (idx >= img.size()) return -1;
            idx += int'(img[idx]) + 3;
        end
        for (int j = idx; j + 3 < img.size(); j++) begin
            if (img[j] == 8'hFF && img[j+1] == 8'hFF && img[j+2] == 8'hFF && img[j+3] == 8'hFF)
                return j;
        end
        return -1;
    endfunction

    function automatic void add_hdr(ref u8 q[$], input u8 fill, input u8 body,
                                    input int l0, input int l1, input int l2, input int l3);
        int lens[4];
        lens = '{l0, l1, l2, l3};
        for (int i = 0; i < 15; i++) q.push_back(fill);
        for (int f = 0; f < 4; f++) begin
            q.push_back(u8'(lens[f]));
            for (int k = 0; k < lens[f] + 2; k++) q.push_back(body);
        end
    endfunction

    function automatic void add_seq(ref u8 q[$], input int n, input u8 first);
        for (int i = 0; i < n; i++) q.push_back(u8'(first + u8'(i)));
    endfunction

    task automatic send_image(input u8 img[$], input bit gaps);
        int s;
        s = find_start(img);
        exp_start = s;
        if (s >= 0) begin
            for (int i = s; i < img.size(); i++) begin
                exp_data.push_back(img[i]);
                exp_last.push_back(i == img.size() - 1);
            end
        end
        for (int i = 0; i < img.size(); i++) begin
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = img[i];
            in_last  = (i == img.size() - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    always @(posedge clk) begin
        #1;
        out_ready = rdy_mode ? ($urandom % 4 != 0) : 1'b1;
    end

    // Cycle-by-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sync_found == pend_found, "R5", "sync_found", sync_found, pend_found);
            if (pend_found)
                chk(payload_offset == 16'(pend_off), "R5", "payload_offset", payload_offset, pend_off);
            chk(sync_missing == pend_miss, "R9", "sync_missing", sync_missing, pend_miss);
            if (pend_found) begin
                in_pass = 1;
                replay_left = 4;
            end
            if (prev_stall) begin
                chk(out_valid && out_data == prev_data && out_last == prev_last, "R11",
                    "held output", out_data, prev_data);
            end
            if (in_pass && replay_left > 0)
                chk(!in_ready, "R6", "in_ready during replay", in_ready, 0);
            else if (in_pass)
                chk(in_ready == out_ready, "R7", "in_ready follows out_ready", in_ready, out_ready);
            if (out_valid && out_ready) begin
                if (exp_data.size() == 0) begin
                    chk(0, "R2", "unexpected output byte", out_data, -1);
                end else begin
                    u8  ed;
                    bit el;
                    ed = exp_data.pop_front();
                    el = exp_last.pop_front();
                    chk(out_data == ed, "R6", "out_data", out_data, ed);
                    chk(out_last == el, "R8", "out_last", out_last, el);
                end
                if (replay_left > 0) replay_left--;
                if (out_last) in_pass = 0;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            prev_last  = out_last;
            pend_found = 0;
            pend_miss  = 0;
            if (in_valid && in_ready) begin
                if (exp_start >= 0 && acc_idx == exp_start + 3) begin
                    pend_found = 1;
                    pend_off   = exp_start;
                end
                if (in_last && exp_start < 0) pend_miss = 1;
                acc_idx = in_last ? 0 : acc_idx + 1;
            end
        end
    end

    initial begin
        u8 img[$];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(sync_found == 1'b0, "R1", "sync_found", sync_found, 0);
        chk(sync_missing == 1'b0, "R1", "sync_missing", sync_missing, 0);
        chk(payload_offset == 16'd0, "R1", "payload_offset", payload_offset, 0);
        @(posedge clk); #1;

        // R3 R4: mixed field lengths, broken runs before the real preamble
        img.delete();
        add_hdr(img, 8'h11, 8'h22, 3, 0, 5, 1);
        img.push_back(8'h12); img.push_back(8'hFF); img.push_back(8'hFF); img.push_back(8'h00);
        img.push_back(8'hFF); img.push_back(8'hFF); img.push_back(8'hFF); img.push_back(8'h05);
        repeat (4) img.push_back(8'hFF);
        add_seq(img, 10, 8'h30);
        send_image(img, 0);

        // R2 R3: 0xFF in the opening bytes and field bodies, a maximum-length field
        rdy_mode = 1;
        img.delete();
        add_hdr(img, 8'hFF, 8'hFF, 255, 2, 0, 7);
        repeat (4) img.push_back(8'hFF);
        add_seq(img, 20, 8'h40);
        send_image(img, 1);

        // R9: image ends with only three 0xFF after the header
        img.delete();
        add_hdr(img, 8'h00, 8'h00, 1, 1, 1, 1);
        repeat (3) img.push_back(8'hFF);
        send_image(img, 0);

        // R9: image ends inside the opening bytes
        img.delete();
        add_seq(img, 10, 8'hF8);
        send_image(img, 1);

        // R8: image ends on the fourth preamble byte
        img.delete();
        add_hdr(img, 8'h5A, 8'h33, 0, 4, 2, 9);
        repeat (4) img.push_back(8'hFF);
        send_image(img, 0);

        // R4: five 0xFF in a row; the payload starts at the first of them
        img.delete();
        add_hdr(img, 8'h01, 8'h02, 6, 6, 6, 6);
        img.push_back(8'h77);
        repeat (5) img.push_back(8'hFF);
        add_seq(img, 3, 8'h90);
        send_image(img, 1);

        // R10: a normal image after error and short images restarts at index 0
        img.delete();
        add_hdr(img, 8'h11, 8'h22, 3, 0, 5, 1);
        img.push_back(8'h12);
        repeat (4) img.push_back(8'hFF);
        add_seq(img, 6, 8'hA0);
        send_image(img, 0);

        begin
            int guard = 0;
            while (exp_data.size() != 0 && guard < 2000) begin
                @(posedge clk);
                guard++;
            end
        end
        repeat (4) @(posedge clk);
        // R6 R10: every expected payload byte came out
        chk(exp_data.size() == 0, "R10", "payload bytes left", exp_data.size(), 0);
        finish_run();
    end

endmodule